// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Four-Channel 12-Bit Converter

This block is the serial control port of a four-channel, 12-bit voltage-output converter. It sits on a two-wire bus as a write-only slave. SCL and SDA are oversampled on the system clock, and the block answers on SDA through an open-drain pull-low output. A transfer that carries the block's 7-bit address is acknowledged. The block then takes pairs of data bytes that each hold a 4-bit command and a 12-bit value. These pairs move values into per-channel input registers and from there into the output registers that drive the converters.

The upper six address bits are fixed by a parameter that selects one of two address families. The lowest address bit follows a strap input, so two devices of each family can share a bus. The address is checked bit by bit as it arrives. On the first wrong bit the block leaves the transfer and waits for the next START.

Registers change only on the SCL falling edge that closes the acknowledge slot of the last byte of a command. A STOP or a repeated START that comes earlier throws the half-received command away. One reserved command pair redirects the following byte to four per-channel shutdown flags.

Top module: `twowire_qdac`

## Requirements
- R1: After reset all four output values, all four input registers and all shutdown flags are zero, and `sda_pull` is low.
- R2: After START, a byte equal to {A6..A1, strap, 0} is acknowledged: `sda_pull` is high while SCL is high in the ninth clock. A6..A1 is 011110 when ALT_ADDR=0 and 101110 when ALT_ADDR=1, and the strap bit follows `addr_strap`.
- R3: An address byte with any wrong bit in A6..A0 is not acknowledged. Every later byte up to the next START is also not acknowledged, and no register changes.
- R4: A write command is a first data byte {C3..C0, D11..D8} followed by a second byte D7..D0. Codes 0000 to 0011 load the input register of channel C1..C0 (0=A, 3=D) and leave the outputs unchanged.
- R5: Codes 0100 to 0111 load the input register of channel C1..C0 and then copy all four input registers to the outputs.
- R6: Code 1000 copies all four input registers to the outputs and ignores the data bits.
- R7: Outputs and shutdown flags change only after the SCL falling edge that ends the acknowledge slot of the last byte. While SCL is high in that ninth clock they still hold their old values.
- R8: A STOP or a repeated START received before the last byte of a command is acknowledged leaves every register unchanged.
- R9: A first byte of 0xF0 makes the next byte a shutdown write: bit0..bit3 set the flags of channels A..D (`chan_off[0]`..`[3]`). The output values are not touched.
- R10: An address byte with R/W=1 that matches is acknowledged. After that `sda_pull` stays low until STOP or START.
- R11: Several commands chained with repeated STARTs and no STOP in between are each carried out in order.
- R12: Codes 1001 to 1111 other than the 0xF0 escape are acknowledged but change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_strap | input | 1 | Lowest address bit |
| sda_pull | output | 1 | High pulls SDA low (open drain) |
| dac_val | output | 48 | Output values, channel A in bits 11:0 up to channel D in bits 47:36 |
| chan_off | output | 4 | Shutdown flags, bit0 = channel A |

## Verification
The hardest conditions to reach from the pins lie between the bytes. One is a command whose first byte has been acknowledged when a repeated START arrives, which must leave no trace even though a complete write follows straight after it. The other is a slave that has dropped out on a wrong address bit and then sees a byte equal to its own address, which it must not answer. The bench reaches both by driving SCL and SDA bit by bit through its own start, stop and byte tasks. It splices a START or STOP directly after a chosen byte, and afterwards it reads the effect through an update-all command and the output values.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH   = 4;
  localparam int DW    = 12;
  localparam int CHW   = $clog2(NCH);
  localparam int BYTEW = 8;
  localparam logic [5:0] ADDR_HI_STD = 6'b011110;
  localparam logic [5:0] ADDR_HI_ALT = 6'b101110;
  localparam logic [7:0] EXT_ESCAPE  = 8'hF0;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_AACK, L_WBYTE, L_WACK, L_READ
  } link_st_t;

  typedef enum logic [1:0] {
    P_CMD, P_LOW, P_EXT
  } phase_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_cond.sv
module qdac_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // data edges while the clock line stays high mark bus conditions
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
endmodule

// File: rtl/qdac_link.sv
module qdac_link
  import qdac_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = ADDR_HI_STD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             strap,
  output logic             sda_pull,
  output logic             wr_begin,
  output logic             byte_done,
  output logic [BYTEW-1:0] byte_q
);
  link_st_t         st;
  logic [2:0]       cnt;
  logic [BYTEW-1:0] sh;
  logic             rw, full;
  logic [6:0]       addr7;

  assign addr7 = {ADDR_HI, strap};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= L_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; full <= 1'b0; sda_pull <= 1'b0;
    end else if (start_ev) begin
      st <= L_ADDR; cnt <= '0; full <= 1'b0; sda_pull <= 1'b0;
    end else if (stop_ev) begin
      st <= L_IDLE; full <= 1'b0; sda_pull <= 1'b0;
    end else begin
      case (st)
        L_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[BYTEW-2:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              rw   <= sda_s;
              full <= 1'b1;
            end else if (sda_s != addr7[3'd6 - cnt]) begin
              st <= L_IDLE;  // early drop-out on first wrong bit
            end
          end else if (scl_fall && full) begin
            full <= 1'b0; sda_pull <= 1'b1; st <= L_AACK;
          end
        end
        L_AACK: if (scl_fall) begin
          sda_pull <= 1'b0; cnt <= '0;
          st <= rw ? L_READ : L_WBYTE;
        end
        L_WBYTE: begin
          if (scl_rise) begin
            sh  <= {sh[BYTEW-2:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full <= 1'b0; sda_pull <= 1'b1; st <= L_WACK;
          end
        end
        L_WACK: if (scl_fall) begin
          sda_pull <= 1'b0; cnt <= '0; st <= L_WBYTE;
        end
        default: ;
      endcase
    end
  end

  // both pulses mark the falling edge that closes an acknowledge slot
  assign wr_begin  = (st == L_AACK) & scl_fall & ~rw;
  assign byte_done = (st == L_WACK) & scl_fall;
  assign byte_q    = sh;
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_rst,
  input  logic              wr_begin,
  input  logic              byte_done,
  input  logic [BYTEW-1:0]  byte_q,
  output logic [NCH*DW-1:0] dac_flat,
  output logic [NCH-1:0]    chan_off
);
  logic [DW-1:0]  in_r  [NCH];
  logic [DW-1:0]  dac_r [NCH];
  phase_t         ph;
  logic [3:0]     cmd_q, hi_q;
  logic [DW-1:0]  new_val;
  logic [CHW-1:0] sel;
  logic           do_load, do_upd;

  assign new_val = {hi_q, byte_q};
  assign sel     = cmd_q[CHW-1:0];
  assign do_load = (ph == P_LOW) && byte_done && (cmd_q[3] == 1'b0);
  assign do_upd  = (ph == P_LOW) && byte_done &&
                   ((cmd_q[3:2] == 2'b01) || (cmd_q == 4'b1000));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= P_CMD; cmd_q <= '0; hi_q <= '0; chan_off <= '0;
      for (int i = 0; i < NCH; i++) begin
        in_r[i]  <= '0;
        dac_r[i] <= '0;
      end
    end else begin
      if (xfer_rst || wr_begin) begin
        ph <= P_CMD;  // drops any half-received command
      end else if (byte_done) begin
        case (ph)
          P_CMD: begin
            cmd_q <= byte_q[7:4];
            hi_q  <= byte_q[3:0];
            ph    <= (byte_q == EXT_ESCAPE) ? P_EXT : P_LOW;
          end
          P_EXT: begin
            chan_off <= byte_q[NCH-1:0];
            ph       <= P_CMD;
          end
          default: ph <= P_CMD;
        endcase
      end
      for (int i = 0; i < NCH; i++) begin
        if (do_load && sel == CHW'(i)) in_r[i] <= new_val;
        if (do_upd) dac_r[i] <= (do_load && sel == CHW'(i)) ? new_val : in_r[i];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign dac_flat[g*DW +: DW] = dac_r[g];
  end
endmodule

// File: rtl/twowire_qdac.sv
module twowire_qdac
  import qdac_pkg::*;
#(
  parameter bit ALT_ADDR = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_strap,
  output logic              sda_pull,
  output logic [NCH*DW-1:0] dac_val,
  output logic [NCH-1:0]    chan_off
);
  localparam logic [5:0] ADDR_HI = ALT_ADDR ? ADDR_HI_ALT : ADDR_HI_STD;

  logic [1:0]       bus_s;
  logic             start_ev, stop_ev, scl_rise, scl_fall;
  logic             wr_begin, byte_done;
  logic [BYTEW-1:0] byte_q;

  qdac_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(bus_s)
  );

  qdac_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  qdac_link #(.ADDR_HI(ADDR_HI)) u_link (
    .clk(clk), .rst(rst), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(bus_s[0]), .strap(addr_strap),
    .sda_pull(sda_pull), .wr_begin(wr_begin), .byte_done(byte_done), .byte_q(byte_q)
  );

  qdac_regs u_regs (
    .clk(clk), .rst(rst), .xfer_rst(start_ev | stop_ev), .wr_begin(wr_begin),
    .byte_done(byte_done), .byte_q(byte_q), .dac_flat(dac_val), .chan_off(chan_off)
  );
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk
  import qdac_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_fall,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              sda_pull,
  input logic [NCH*DW-1:0] dac_val,
  input logic [NCH-1:0]    chan_off
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_val == '0 && chan_off == '0 && !sda_pull));

  a_r7_dac_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_val) |-> $past(scl_fall));

  a_r9_off_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_off) |-> $past(scl_fall));

  a_r2_pull_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> $past(scl_fall || start_ev || stop_ev));

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_pull);
endmodule

bind twowire_qdac qdac_chk u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_pull(sda_pull), .dac_val(dac_val), .chan_off(chan_off)
);

// File: tb/sim_twowire_qdac.sv
module sim_twowire_qdac;
  localparam int H = 8;
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{16'h0123, 16'h1456, 16'h4789, 16'h2ABC,
                                        16'h8000, 16'h9FFF, 16'h7DEF, 16'hF5AA};

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_drv = 1'b1, strap = 1'b0;
  logic sda_line, sda_pull;
  logic [47:0] dac_val;
  logic [3:0]  chan_off;
  int n_run = 0, n_fail = 0;
  logic last_ack, bit_pull;
  logic [47:0] pre_dac;
  logic [11:0] ref_in [4];
  logic [11:0] ref_dac [4];

  assign sda_line = sda_drv & ~sda_pull;
  always #5 clk = ~clk;

  twowire_qdac u0 (.clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .addr_strap(strap), .sda_pull(sda_pull), .dac_val(dac_val), .chan_off(chan_off));

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bstart();
    sda_drv = 1'b1; cyc(H); scl = 1'b1; cyc(H); sda_drv = 1'b0; cyc(H); scl = 1'b0; cyc(2);
  endtask

  task automatic bstop();
    sda_drv = 1'b0; cyc(H); scl = 1'b1; cyc(H); sda_drv = 1'b1; cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; cyc(H); scl = 1'b1; cyc(H/2);
      if (sda_pull) bit_pull = 1'b1;
      cyc(H/2); scl = 1'b0; cyc(2);
    end
    sda_drv = 1'b1; cyc(H); scl = 1'b1; cyc(H/2);
    last_ack = sda_pull; pre_dac = dac_val;
    cyc(H/2); scl = 1'b0; cyc(2);
  endtask

  function automatic logic [47:0] packed_ref();
    return {ref_dac[3], ref_dac[2], ref_dac[1], ref_dac[0]};
  endfunction

  task automatic model(input logic [15:0] v);
    if (v[15] == 1'b0) ref_in[v[13:12]] = v[11:0];
    if (v[15:14] == 2'b01 || v[15:12] == 4'h8)
      for (int i = 0; i < 4; i++) ref_dac[i] = ref_in[i];
  endtask

  function automatic string tag_of(input logic [3:0] c);
    if (c[3:2] == 2'b00) return "R4 load only";
    if (c[3:2] == 2'b01) return "R5 load and update";
    if (c == 4'h8) return "R6 update all";
    return "R12 unused code ignored";
  endfunction

  initial begin
    cyc(150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 48'h0, 48'h1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] old;
    for (int i = 0; i < 4; i++) begin ref_in[i] = '0; ref_dac[i] = '0; end
    cyc(5); rst = 1'b0; cyc(3);
    chk(dac_val == '0 && chan_off == '0 && !sda_pull, "R1 reset state",
        {dac_val[43:0], chan_off}, 48'h0);

    // table of commands, each in its own transfer
    for (int k = 0; k < NV; k++) begin
      old = packed_ref();
      bstart(); send_byte(8'h78);
      chk(last_ack, "R2 address ack strap 0", 48'(last_ack), 48'h1);
      send_byte(VEC[k][15:8]); send_byte(VEC[k][7:0]);
      chk(pre_dac == old, "R7 outputs held during ack slot", pre_dac, old);
      bstop(); cyc(4);
      model(VEC[k]);
      chk(dac_val == packed_ref(), tag_of(VEC[k][15:12]), dac_val, packed_ref());
    end

    // wrong address, then a byte equal to the real address
    old = packed_ref();
    bstart(); send_byte(8'h70);
    chk(!last_ack, "R3 wrong address not acked", 48'(last_ack), 48'h0);
    send_byte(8'h78);
    chk(!last_ack, "R3 idle until next START", 48'(last_ack), 48'h0);
    send_byte(8'h48); send_byte(8'h88); bstop(); cyc(4);
    chk(dac_val == old, "R3 no register change", dac_val, old);

    // abort by STOP, then abort by repeated START
    bstart(); send_byte(8'h78); send_byte(8'h4F); bstop(); cyc(4);
    chk(dac_val == old, "R8 STOP abort", dac_val, old);
    bstart(); send_byte(8'h78); send_byte(8'h4F);
    bstart(); send_byte(8'h78); send_byte(8'h32); send_byte(8'h22); bstop();
    model(16'h3222);
    bstart(); send_byte(8'h78); send_byte(8'h80); send_byte(8'h00); bstop(); cyc(4);
    model(16'h8000);
    chk(dac_val == packed_ref(), "R8 repeated START abort", dac_val, packed_ref());
    bstart(); send_byte(8'h78); send_byte(8'hF0); bstop(); cyc(4);
    chk(chan_off == 4'h0, "R8 aborted shutdown write", 48'(chan_off), 48'h0);

    // shutdown writes
    old = packed_ref();
    bstart(); send_byte(8'h78); send_byte(8'hF0); send_byte(8'h0A); bstop(); cyc(4);
    chk(chan_off == 4'b1010, "R9 shutdown B and D", 48'(chan_off), 48'hA);
    chk(dac_val == old, "R9 outputs untouched", dac_val, old);
    bstart(); send_byte(8'h78); send_byte(8'hF0); send_byte(8'h05); bstop(); cyc(4);
    chk(chan_off == 4'b0101, "R9 shutdown A and C", 48'(chan_off), 48'h5);

    // chained transfers with repeated START
    bstart(); send_byte(8'h78); send_byte(8'h01); send_byte(8'h11);
    bstart(); send_byte(8'h78); send_byte(8'h12); send_byte(8'h22);
    bstart(); send_byte(8'h78); send_byte(8'h80); send_byte(8'h00); bstop(); cyc(4);
    model(16'h0111); model(16'h1222); model(16'h8000);
    chk(dac_val == packed_ref(), "R11 chained commands", dac_val, packed_ref());

    // strap set to 1
    strap = 1'b1; cyc(4);
    bstart(); send_byte(8'h78);
    chk(!last_ack, "R3 strap 1 rejects A0=0", 48'(last_ack), 48'h0);
    bstop();
    bstart(); send_byte(8'h7A);
    chk(last_ack, "R2 address ack strap 1", 48'(last_ack), 48'h1);
    send_byte(8'h43); send_byte(8'h33); bstop(); cyc(4);
    model(16'h4333);
    chk(dac_val == packed_ref(), "R2 write with strap 1", dac_val, packed_ref());
    strap = 1'b0; cyc(4);

    // read address
    old = packed_ref();
    bstart(); send_byte(8'h79);
    chk(last_ack, "R10 read address acked", 48'(last_ack), 48'h1);
    send_byte(8'hFF);
    chk(!bit_pull && !last_ack, "R10 SDA released in read",
        48'({bit_pull, last_ack}), 48'h0);
    bstop(); cyc(4);
    chk(dac_val == old, "R10 no change on read", dac_val, old);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule